// File: doc/BRIEF.md
# Predicate-Gated Dual Issue Stage

This block sits at the issue point of a statically scheduled pipeline. It keeps a bank of one-bit condition flags and uses them to cancel the side effects of instructions that should not take effect. A compare operation fills two flags at once: the first receives the compare outcome and the second receives its inverse. Every issuing instruction names one flag as its guard. When that guard reads false, the instruction keeps flowing down the pipe, but its register-file and memory write strobes are removed. It then behaves as a no-operation.

Because a paired compare always leaves exactly one of its two flags true, the scheduler can put both arms of an if/else side by side in one issue cycle. Each arm is guarded by a different flag of the pair, and only one arm retires its results. Two issue lanes are handled per cycle, and each lane is gated on its own. Flag 0 is a constant true guard for instructions that are not conditional.

Top module: `pred_issue_gate`

## Requirements
- R1: After reset, every writable flag (indices 1 to 63) reads false, so any valid instruction guarded by one of them is squashed.
- R2: Flag 0 always reads true, so a valid instruction guarded by flag 0 is never squashed.
- R3: A compare naming flag 0 as either destination leaves flag 0 true. The other destination is still written.
- R4: A compare with `cmp_en` high writes `cmp_res` into flag `cmp_dst_t` and the inverse of `cmp_res` into flag `cmp_dst_f`.
- R5: A valid instruction whose guard reads false has `out_rf_we` and `out_mem_we` forced to 0 and `out_squash` set to 1.
- R6: A valid instruction whose guard reads true passes `in_rf_we` and `in_mem_we` through unchanged, with `out_squash` at 0.
- R7: A flag written by a compare takes its new value at the next rising clock edge. An instruction reading that flag in the same cycle as the compare still sees the old value.
- R8: Lane 0 uses bits [5:0] of `in_guard` and lane 1 uses bits [11:6]. The two lanes are gated independently. When they are guarded by the two flags of one compare pair, exactly one lane is squashed.
- R9: If `cmp_dst_t` and `cmp_dst_f` name the same nonzero flag, that flag receives `cmp_res`.
- R10: An instruction with `in_valid` at 0 drives all three of its lane outputs to 0, whatever its guard and enables.
- R11: With `cmp_en` at 0, no flag changes, whatever values are on the other compare inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cmp_en | input | 1 | Compare write strobe |
| cmp_res | input | 1 | Compare outcome |
| cmp_dst_t | input | 6 | Flag that receives the outcome |
| cmp_dst_f | input | 6 | Flag that receives the inverted outcome |
| in_valid | input | 2 | Per-lane instruction valid |
| in_guard | input | 12 | Per-lane guard index, lane 0 in bits [5:0] |
| in_rf_we | input | 2 | Per-lane requested register write enable |
| in_mem_we | input | 2 | Per-lane requested memory write enable |
| out_rf_we | output | 2 | Per-lane gated register write enable |
| out_mem_we | output | 2 | Per-lane gated memory write enable |
| out_squash | output | 2 | Per-lane flag: instruction cancelled by its guard |

## Verification
The hardest situation to reach is a compare and a reader of its destination flag in the same cycle. The test has to see the old value in that cycle and the new value one edge later. The stimulus holds the compare on the inputs during one low clock phase and places a lane instruction guarded by the destination flag in the same window. It samples the lane before the edge, then samples it again after the edge. Complementary dual issue is reached by writing a flag pair and then issuing both lanes at once, each guarded by one flag of the pair. Both polarities of the compare outcome are covered.

// File: rtl/pred_issue_pkg.sv
package pred_issue_pkg;

   typedef struct packed {
      logic rf_we;
      logic mem_we;
   } side_eff_t;

   localparam side_eff_t SIDE_NONE = '{rf_we: 1'b0, mem_we: 1'b0};

endpackage

// File: rtl/pred_flag_bank.sv
module pred_flag_bank #(
   parameter int  NUM_PRED  = 64,
   parameter int  RD_PORTS  = 2,
   parameter bit  ZERO_TRUE = 1'b1,
   localparam int IW        = $clog2(NUM_PRED)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   wr_val,
   input  logic [IW-1:0]          wr_idx_t,
   input  logic [IW-1:0]          wr_idx_f,
   input  logic [RD_PORTS*IW-1:0] rd_idx,
   output logic [RD_PORTS-1:0]    rd_val
);

   logic [NUM_PRED-1:0] flags;

   for (genvar r = 0; r < NUM_PRED; r++) begin : g_cell
      if (ZERO_TRUE && r == 0) begin : g_const
         assign flags[r] = 1'b1;
      end else begin : g_store
         logic cell_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cell_q <= 1'b0;
            end else if (wr_en && wr_idx_t == IW'(r)) begin
               cell_q <= wr_val;
            end else if (wr_en && wr_idx_f == IW'(r)) begin
               cell_q <= ~wr_val;
            end
         end
         assign flags[r] = cell_q;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_val[p] = flags[rd_idx[p*IW +: IW]];
   end

endmodule

// File: rtl/pred_lane_gate.sv
module pred_lane_gate
   import pred_issue_pkg::*;
(
   input  logic      valid,
   input  logic      guard_true,
   input  side_eff_t req,
   output side_eff_t grant,
   output logic      squash
);

   always_comb begin
      grant  = SIDE_NONE;
      squash = 1'b0;
      if (valid) begin
         if (guard_true) begin
            grant = req;
         end else begin
            squash = 1'b1;
         end
      end
   end

endmodule

// File: rtl/pred_issue_gate.sv
module pred_issue_gate
   import pred_issue_pkg::*;
#(
   parameter int  NUM_PRED  = 64,
   parameter int  LANES     = 2,
   parameter bit  ZERO_TRUE = 1'b1,
   localparam int IW        = $clog2(NUM_PRED)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmp_en,
   input  logic                cmp_res,
   input  logic [IW-1:0]       cmp_dst_t,
   input  logic [IW-1:0]       cmp_dst_f,
   input  logic [LANES-1:0]    in_valid,
   input  logic [LANES*IW-1:0] in_guard,
   input  logic [LANES-1:0]    in_rf_we,
   input  logic [LANES-1:0]    in_mem_we,
   output logic [LANES-1:0]    out_rf_we,
   output logic [LANES-1:0]    out_mem_we,
   output logic [LANES-1:0]    out_squash
);

   if (NUM_PRED < 2 || (1 << IW) != NUM_PRED) begin : g_bad_count
      $error("pred_issue_gate: NUM_PRED must be a power of two, at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("pred_issue_gate: LANES must be at least 1");
   end

   logic [LANES-1:0] guard_val;

   pred_flag_bank #(
      .NUM_PRED  (NUM_PRED),
      .RD_PORTS  (LANES),
      .ZERO_TRUE (ZERO_TRUE)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cmp_en),
      .wr_val   (cmp_res),
      .wr_idx_t (cmp_dst_t),
      .wr_idx_f (cmp_dst_f),
      .rd_idx   (in_guard),
      .rd_val   (guard_val)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      side_eff_t req, grant;
      assign req.rf_we  = in_rf_we[l];
      assign req.mem_we = in_mem_we[l];

      pred_lane_gate u_gate (
         .valid      (in_valid[l]),
         .guard_true (guard_val[l]),
         .req        (req),
         .grant      (grant),
         .squash     (out_squash[l])
      );

      assign out_rf_we[l]  = grant.rf_we;
      assign out_mem_we[l] = grant.mem_we;
   end

endmodule

// File: rtl/pred_issue_chk.sv
module pred_issue_chk #(
   parameter int  NUM_PRED = 64,
   parameter int  LANES    = 2,
   localparam int IW       = $clog2(NUM_PRED)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmp_en,
   input logic                cmp_res,
   input logic [IW-1:0]       cmp_dst_t,
   input logic [IW-1:0]       cmp_dst_f,
   input logic [LANES-1:0]    in_valid,
   input logic [LANES*IW-1:0] in_guard,
   input logic [LANES-1:0]    in_rf_we,
   input logic [LANES-1:0]    in_mem_we,
   input logic [LANES-1:0]    out_rf_we,
   input logic [LANES-1:0]    out_mem_we,
   input logic [LANES-1:0]    out_squash
);

   logic pair_ok;
   assign pair_ok = cmp_en && cmp_dst_t != '0 && cmp_dst_f != '0 && cmp_dst_t != cmp_dst_f;

   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid[l] |-> (!out_rf_we[l] && !out_mem_we[l] && !out_squash[l]));

      a_r5_squash_kills: assert property (@(posedge clk) disable iff (!rst_n)
         out_squash[l] |-> (!out_rf_we[l] && !out_mem_we[l]));

      a_r6_no_invented_write: assert property (@(posedge clk) disable iff (!rst_n)
         (out_rf_we[l] |-> in_rf_we[l]) and (out_mem_we[l] |-> in_mem_we[l]));

      a_r2_zero_guard_live: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid[l] && in_guard[l*IW +: IW] == '0) |-> !out_squash[l]);
   end

   a_r4_pair_value: assert property (@(posedge clk) disable iff (!rst_n)
      pair_ok |=> (!(in_valid[0] && in_guard[IW-1:0] == $past(cmp_dst_t))
                   || (out_squash[0] == !$past(cmp_res))));

   if (LANES >= 2) begin : g_dual
      a_r8_one_arm_retires: assert property (@(posedge clk) disable iff (!rst_n)
         pair_ok |=> (!(in_valid[0] && in_valid[1]
                        && in_guard[IW-1:0] == $past(cmp_dst_t)
                        && in_guard[2*IW-1:IW] == $past(cmp_dst_f))
                      || (out_squash[0] != out_squash[1])));
   end

endmodule

bind pred_issue_gate pred_issue_chk #(
   .NUM_PRED (NUM_PRED),
   .LANES    (LANES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmp_en     (cmp_en),
   .cmp_res    (cmp_res),
   .cmp_dst_t  (cmp_dst_t),
   .cmp_dst_f  (cmp_dst_f),
   .in_valid   (in_valid),
   .in_guard   (in_guard),
   .in_rf_we   (in_rf_we),
   .in_mem_we  (in_mem_we),
   .out_rf_we  (out_rf_we),
   .out_mem_we (out_mem_we),
   .out_squash (out_squash)
);

// File: tb/pred_issue_gate_tb.sv
`timescale 1ns/1ps
module pred_issue_gate_tb;

   localparam int NP = 64;
   localparam int IW = 6;
   localparam int L  = 2;

   logic          clk;
   logic          rst_n;
   logic          cmp_en, cmp_res;
   logic [IW-1:0] cmp_dst_t, cmp_dst_f;
   logic [L-1:0]  in_valid, in_rf_we, in_mem_we;
   logic [L*IW-1:0] in_guard;
   logic [L-1:0]  out_rf_we, out_mem_we, out_squash;

   int  n_chk  = 0;
   int  n_fail = 0;
   logic exp_p [NP];

   pred_issue_gate u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmp_en(cmp_en), .cmp_res(cmp_res),
      .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
      .in_valid(in_valid), .in_guard(in_guard),
      .in_rf_we(in_rf_we), .in_mem_we(in_mem_we),
      .out_rf_we(out_rf_we), .out_mem_we(out_mem_we), .out_squash(out_squash)
   );

   initial begin
      clk = 1'b0;
      forever #2.5 clk = ~clk;
   end

   task automatic check(string req, logic [2:0] act, logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {squash,rf,mem} actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [2:0] lane_out(int l);
      return {out_squash[l], out_rf_we[l], out_mem_we[l]};
   endfunction

   function automatic logic [2:0] model(logic v, int g, logic rf, logic mem);
      if (!v) return 3'b000;
      if (!exp_p[g]) return 3'b100;
      return {1'b0, rf, mem};
   endfunction

   task automatic set_lane(int l, logic v, int g, logic rf, logic mem);
      in_valid[l]            = v;
      in_guard[l*IW +: IW]   = IW'(g);
      in_rf_we[l]            = rf;
      in_mem_we[l]           = mem;
   endtask

   task automatic clear_lanes();
      in_valid = '0; in_guard = '0; in_rf_we = '0; in_mem_we = '0;
   endtask

   function automatic void model_cmp(int t, int f, logic res);
      if (f != 0) exp_p[f] = ~res;
      if (t != 0) exp_p[t] = res;
   endfunction

   task automatic do_cmp(int t, int f, logic res);
      @(negedge clk);
      cmp_en = 1'b1; cmp_res = res;
      cmp_dst_t = IW'(t); cmp_dst_f = IW'(f);
      @(negedge clk);
      cmp_en = 1'b0;
      model_cmp(t, f, res);
   endtask

   task automatic probe(string req, int l, int g, logic rf, logic mem);
      clear_lanes();
      set_lane(l, 1'b1, g, rf, mem);
      #1;
      check(req, lane_out(l), model(1'b1, g, rf, mem));
   endtask

   task automatic t_reset();
      probe("R1", 0, 5, 1'b1, 1'b1);
      probe("R1", 1, 63, 1'b1, 1'b0);
      probe("R1", 0, 1, 1'b0, 1'b1);
      probe("R2", 1, 0, 1'b1, 1'b1);
   endtask

   task automatic t_compare();
      do_cmp(3, 4, 1'b1);
      probe("R4", 0, 3, 1'b1, 1'b1);
      probe("R4", 1, 4, 1'b1, 1'b1);
      do_cmp(3, 4, 1'b0);
      probe("R4", 0, 3, 1'b1, 1'b0);
      probe("R4", 0, 4, 1'b1, 1'b0);
   endtask

   task automatic t_guard_pass();
      probe("R6", 0, 4, 1'b1, 1'b0);
      probe("R6", 1, 4, 1'b0, 1'b1);
      probe("R5", 1, 3, 1'b1, 1'b1);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      clear_lanes();
      cmp_en = 1'b1; cmp_res = 1'b1; cmp_dst_t = 6'd10; cmp_dst_f = 6'd11;
      set_lane(0, 1'b1, 10, 1'b1, 1'b1);
      #1;
      check("R7 before edge", lane_out(0), 3'b100);
      @(negedge clk);
      cmp_en = 1'b0;
      model_cmp(10, 11, 1'b1);
      #1;
      check("R7 after edge", lane_out(0), 3'b011);
   endtask

   task automatic t_zero_write();
      do_cmp(0, 7, 1'b0);
      probe("R3", 0, 0, 1'b1, 1'b1);
      probe("R3", 1, 7, 1'b1, 1'b1);
      do_cmp(8, 0, 1'b1);
      probe("R3", 0, 0, 1'b0, 1'b1);
      probe("R3", 1, 8, 1'b0, 1'b1);
   endtask

   task automatic t_dual();
      for (int pol = 0; pol < 2; pol++) begin
         do_cmp(20, 21, logic'(pol));
         clear_lanes();
         set_lane(0, 1'b1, 20, 1'b1, 1'b1);
         set_lane(1, 1'b1, 21, 1'b1, 1'b1);
         #1;
         check("R8 lane0", lane_out(0), model(1'b1, 20, 1'b1, 1'b1));
         check("R8 lane1", lane_out(1), model(1'b1, 21, 1'b1, 1'b1));
      end
   endtask

   task automatic t_same_dst();
      do_cmp(30, 30, 1'b1);
      probe("R9", 0, 30, 1'b1, 1'b1);
      do_cmp(30, 30, 1'b0);
      probe("R9", 1, 30, 1'b1, 1'b1);
   endtask

   task automatic t_invalid();
      clear_lanes();
      set_lane(0, 1'b0, 0, 1'b1, 1'b1);
      set_lane(1, 1'b0, 5, 1'b1, 1'b1);
      #1;
      check("R10 lane0", lane_out(0), 3'b000);
      check("R10 lane1", lane_out(1), 3'b000);
   endtask

   task automatic t_cmp_idle();
      @(negedge clk);
      cmp_en = 1'b0; cmp_res = 1'b0; cmp_dst_t = 6'd10; cmp_dst_f = 6'd3;
      @(negedge clk);
      probe("R11", 0, 10, 1'b1, 1'b1);
      probe("R11", 1, 3, 1'b1, 1'b1);
   endtask

   initial begin
      for (int i = 0; i < NP; i++) exp_p[i] = (i == 0);
      rst_n = 1'b0;
      cmp_en = 1'b0; cmp_res = 1'b0; cmp_dst_t = '0; cmp_dst_f = '0;
      clear_lanes();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_compare();
      t_guard_pass();
      t_same_cycle();
      t_zero_write();
      t_dual();
      t_same_dst();
      t_invalid();
      t_cmp_idle();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule